// File: doc/BRIEF.md
# SPI Receive DMA with Word Packing and CRC-8

This block sits between the byte output of an SPI master's shift register and a 32-bit wide system RAM. Before a transfer, firmware sets a byte start address, a byte count, an 8-bit CRC seed and a number of leading bytes to keep out of the CRC. A start pulse arms the engine. Each valid byte from the shifter is placed in its byte lane, and the gathered bytes go to memory as full 32-bit word writes. An 8-bit CRC runs over every byte except the leading skipped ones.

The start address is a byte address, so a buffer may begin and end anywhere inside a word. The memory port has no byte enables. Every write covers a whole word, so the lanes below the first byte and above the last byte of the buffer are left undefined. Before the engine arms, each request is checked: a zero length, or a buffer that would run past the top of the RAM, is refused with a one-cycle error pulse. When the programmed count has been stored, the block pulses done and presents the final CRC.

Top module: `spi_rx_dma`

## Requirements
- R1: A start with a byte count of zero is refused: `cfg_err` is high for the one cycle after the start, `busy` stays low and no memory write occurs.
- R2: A start whose start address plus byte count is greater than the RAM size (2^ADDR_W bytes) is refused in the same way as R1. A buffer that ends exactly on the last RAM byte is accepted.
- R3: Received byte number i is stored at byte address start+i. That is memory word (start+i)>>2, bits [8*((start+i)%4) +: 8], little-endian. Every write asserts `mem_we` with a full 32-bit `mem_wdata`.
- R4: A word is written when its lane 3 is filled or when the byte count is reached, whichever comes first. A buffer therefore produces exactly ((start+len-1)>>2) - (start>>2) + 1 writes.
- R5: `done` is high for exactly one cycle, in the cycle right after the final word write, and `busy` is low from that cycle on.
- R6: The CRC is CRC-8 with polynomial 0x07, processed MSB first (crc ^= byte, then 8 shift/conditional-XOR steps). It covers the received bytes with index >= the skip count. Its final value is on `crc_out` while `done` is high. A skip count at or above the length leaves the CRC unchanged.
- R7: `crc_load` while idle loads `cfg_seed` into the CRC, and it may come in the same cycle as `start`. Without it, the next transfer continues from the previous CRC value. `crc_load` while busy is ignored. After reset the CRC holds 0xFF.
- R8: A `start` while a transfer is in progress is ignored. The running transfer keeps the address, length and skip count it latched when it began.
- R9: `in_valid` while idle is ignored: no memory write and no CRC change.
- R10: Idle cycles between valid bytes do not change where bytes are stored or the CRC result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_addr | input | ADDR_W | Byte start address of the receive buffer |
| cfg_len | input | ADDR_W+1 | Number of bytes to receive |
| cfg_seed | input | 8 | CRC seed value |
| cfg_skip | input | ADDR_W+1 | Leading bytes excluded from the CRC |
| start | input | 1 | Start request pulse |
| crc_load | input | 1 | Load seed into CRC register (idle only) |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | One-cycle configuration-refused pulse |
| crc_out | output | 8 | Current CRC value |

## Verification
The bench sweeps every start-address phase across two words against lengths from one to nine bytes. Each result is compared with a reference model that stores bytes by address and runs CRC-8 in software, so a wrong lane mapping or a missed flush of a partial last word shows up as a wrong stored byte or a wrong write count. Errors in the skip comparison appear as CRC mismatches. A buffer that ends exactly at the top of RAM is run beside one that overflows by a single byte, which catches an off-by-one in the range check. The bench also starts a transfer without reloading the seed, sends start and seed-load requests in the middle of a transfer, and sends bytes while idle. A design that re-arms, reseeds or stores stray bytes in those cases fails the CRC or write-count checks.

// File: rtl/spi_rx_dma_pkg.sv
// Package: shared state encoding and the CRC-8 byte step used by the
// receive DMA. Assumes CRC processed MSB first, one byte per call.
package spi_rx_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } dma_state_e;

    // Advance an 8-bit CRC by one byte, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] data_in,
                                             input logic [7:0] poly);
        logic [7:0] r;
        r = crc_in ^ data_in;
        for (int b = 0; b < 8; b++) begin
            r = r[7] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxd_cfg_check.sv
// Module: combinational validation of a transfer request.
// Accepts a request only when the length is non-zero and the buffer
// [start, start+len) fits inside a RAM of 2^ADDR_W bytes.
module rxd_cfg_check #(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  len,
    output logic              ok
);
    localparam int SUM_W = LEN_W + 1;
    localparam logic [SUM_W-1:0] RAM_BYTES = SUM_W'(1) << ADDR_W;

    logic [SUM_W-1:0] end_excl;

    // Compute the exclusive end address and compare with the RAM size.
    always_comb begin
        end_excl = SUM_W'(start_addr) + SUM_W'(len);
        ok       = (len != '0) && (end_excl <= RAM_BYTES);
    end
endmodule

// File: rtl/rxd_crc_unit.sv
// Module: CRC-8 register. A load writes the seed; otherwise each enabled
// byte advances the CRC. Load wins over enable. Resets to INIT.
module rxd_crc_unit
    import spi_rx_dma_pkg::*;
#(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] seed,
    input  logic       en,
    input  logic [7:0] data,
    output logic [7:0] crc
);
    logic [7:0] crc_q;

    // Hold, seed or advance the CRC once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (load) begin
            crc_q <= seed;
        end else if (en) begin
            crc_q <= crc8_step(crc_q, data, POLY);
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/rxd_word_packer.sv
// Module: gathers bytes into four little-endian lanes and emits a full
// word write when told to flush. Lanes not refreshed in the current
// buffer keep stale content, which the caller treats as undefined.
module rxd_word_packer #(
    parameter int WADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_en,
    input  logic [7:0]         byte_data,
    input  logic [1:0]         lane,
    input  logic [WADDR_W-1:0] word_addr,
    input  logic               flush,
    output logic               we,
    output logic [WADDR_W-1:0] addr,
    output logic [31:0]        wdata
);
    localparam int LANES = 4;

    logic [LANES-1:0][7:0] lanes_q;
    logic [LANES-1:0][7:0] merged;

    // Merge the incoming byte into its lane so a flush sees it at once.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            merged[g] = (byte_en && (lane == 2'(g))) ? byte_data : lanes_q[g];
        end
    end

    // Keep the lane buffer up to date with accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_q <= '0;
        end else if (byte_en) begin
            lanes_q <= merged;
        end
    end

    // Register the outgoing word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we    <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else begin
            we <= flush;
            if (flush) begin
                addr  <= word_addr;
                wdata <= merged;
            end
        end
    end
endmodule

// File: rtl/spi_rx_dma.sv
// Module: top of the SPI receive DMA. Validates a request on start,
// walks a byte address across the buffer, packs bytes into word writes
// and runs CRC-8 over bytes past the skip count. Assumes the shifter
// presents at most one byte per cycle with in_valid.
module spi_rx_dma
    import spi_rx_dma_pkg::*;
#(
    parameter int         ADDR_W   = 10,
    parameter logic [7:0] CRC_POLY = 8'h07,
    parameter logic [7:0] CRC_INIT = 8'hFF,
    localparam int        LEN_W    = ADDR_W + 1,
    localparam int        WADDR_W  = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_start_addr,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [7:0]         cfg_seed,
    input  logic [LEN_W-1:0]   cfg_skip,
    input  logic               start,
    input  logic               crc_load,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [31:0]        mem_wdata,
    output logic               busy,
    output logic               done,
    output logic               cfg_err,
    output logic [7:0]         crc_out
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    dma_state_e         state_q;
    logic [ADDR_W-1:0]  cur_addr_q;
    logic [LEN_W-1:0]   cnt_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   skip_q;
    logic               done_q;
    logic               err_q;

    logic               cfg_ok;
    logic               idle;
    logic               take_start;
    logic               byte_take;
    logic               last_byte;
    logic               flush;
    logic               crc_en;
    logic               crc_seed_ld;

    rxd_cfg_check #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_cfg (
        .start_addr (cfg_start_addr),
        .len        (cfg_len),
        .ok         (cfg_ok)
    );

    // Decode per-cycle control from the state and the inputs.
    always_comb begin
        idle        = (state_q == ST_IDLE);
        take_start  = start && idle;
        byte_take   = in_valid && (state_q == ST_RUN);
        last_byte   = byte_take && ((cnt_q + LEN_ONE) == len_q);
        flush       = byte_take && (last_byte || (cur_addr_q[1:0] == 2'b11));
        crc_en      = byte_take && (cnt_q >= skip_q);
        crc_seed_ld = crc_load && idle;
    end

    // Sequence idle -> run -> tail -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (take_start && cfg_ok) state_q <= ST_RUN;
                ST_RUN:  if (last_byte)            state_q <= ST_TAIL;
                ST_TAIL:                           state_q <= ST_IDLE;
                default:                           state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the request on an accepted start and walk address and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            cnt_q      <= '0;
            len_q      <= '0;
            skip_q     <= '0;
        end else if (take_start && cfg_ok) begin
            cur_addr_q <= cfg_start_addr;
            cnt_q      <= '0;
            len_q      <= cfg_len;
            skip_q     <= cfg_skip;
        end else if (byte_take) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(1);
            cnt_q      <= cnt_q + LEN_ONE;
        end
    end

    // Produce the one-cycle done and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_TAIL);
            err_q  <= take_start && !cfg_ok;
        end
    end

    rxd_word_packer #(
        .WADDR_W (WADDR_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_en   (byte_take),
        .byte_data (in_data),
        .lane      (cur_addr_q[1:0]),
        .word_addr (cur_addr_q[ADDR_W-1:2]),
        .flush     (flush),
        .we        (mem_we),
        .addr      (mem_addr),
        .wdata     (mem_wdata)
    );

    rxd_crc_unit #(
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (crc_seed_ld),
        .seed  (cfg_seed),
        .en    (crc_en),
        .data  (in_data),
        .crc   (crc_out)
    );

    assign busy    = !idle;
    assign done    = done_q;
    assign cfg_err = err_q;
endmodule

// File: rtl/spi_rx_dma_checker.sv
// Module: temporal checks on the receive DMA ports, bound to the top.
module spi_rx_dma_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       crc_load,
    input logic       mem_we,
    input logic       busy,
    input logic       done,
    input logic       cfg_err,
    input logic [7:0] crc_out
);
    assert_err_keeps_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);

    assert_write_inside_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_done_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we));

    assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_crc_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(crc_load)) |-> $stable(crc_out));

    assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind spi_rx_dma spi_rx_dma_checker u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .crc_load (crc_load),
    .mem_we   (mem_we),
    .busy     (busy),
    .done     (done),
    .cfg_err  (cfg_err),
    .crc_out  (crc_out)
);

// File: tb/sim_spi_rx_dma.sv
`timescale 1ns/1ps
module sim_spi_rx_dma;
    localparam int AW    = 6;
    localparam int LW    = AW + 1;
    localparam int WORDS = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_start_addr = '0;
    logic [LW-1:0] cfg_len = '0;
    logic [7:0]    cfg_seed = 8'hFF;
    logic [LW-1:0] cfg_skip = '0;
    logic          start = 1'b0;
    logic          crc_load = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          mem_we;
    logic [AW-3:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          busy, done, cfg_err;
    logic [7:0]    crc_out;

    spi_rx_dma #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start_addr(cfg_start_addr),
        .cfg_len(cfg_len), .cfg_seed(cfg_seed), .cfg_skip(cfg_skip),
        .start(start), .crc_load(crc_load), .in_valid(in_valid),
        .in_data(in_data), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .cfg_err(cfg_err), .crc_out(crc_out)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int cycles = 0;
    bit prev_we = 1'b0;
    bit prev_done = 1'b0;
    logic [31:0] bmem [WORDS];
    logic [7:0]  crc_model = 8'hFF;

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] pat(input int i, input int t);
        return 8'((i * 37 + t * 11 + 5) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Port monitor: memory model, write count, done timing (R5).
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                bmem[mem_addr] = mem_wdata;
                wr_cnt++;
            end
            if (done) begin
                done_cnt++;
                check(prev_we, "R5 done after write", 0, 1);
                check(!prev_done, "R5 done single pulse", 1, 0);
                check(!busy, "R5 busy low at done", 1, 0);
            end
            prev_we   = mem_we;
            prev_done = done;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_sim();
        end
    end

    task automatic run_xfer(input int a, input int l, input int sk, input logic [7:0] seed,
                            input bit load, input int gap, input bit poke, input int tag);
        logic [7:0] c;
        int wr0, dn0, exp_wr, b;
        @(negedge clk);
        cfg_start_addr = AW'(a); cfg_len = LW'(l); cfg_skip = LW'(sk);
        cfg_seed = seed; start = 1'b1; crc_load = load;
        c = load ? seed : crc_model;
        for (int i = 0; i < l; i++) if (i >= sk) c = ref_crc(c, pat(i, tag));
        @(negedge clk);
        start = 1'b0; crc_load = 1'b0;
        #1;
        wr0 = wr_cnt; dn0 = done_cnt;
        for (int i = 0; i < l; i++) begin
            in_valid = 1'b1; in_data = pat(i, tag);
            if (poke && i == 0) begin
                start = 1'b1; crc_load = 1'b1; cfg_seed = ~seed;
                cfg_start_addr = AW'(a + 5); cfg_len = LW'(1); cfg_skip = '0;
            end
            @(negedge clk);
            in_valid = 1'b0; start = 1'b0; crc_load = 1'b0;
            repeat (gap) @(negedge clk);
        end
        for (int w = 0; w < 12 && done_cnt == dn0; w++) begin
            @(negedge clk); #1;
        end
        check(done_cnt == dn0 + 1, "R5 done seen", done_cnt - dn0, 1);
        exp_wr = ((a + l - 1) >> 2) - (a >> 2) + 1;
        check(wr_cnt - wr0 == exp_wr, "R4 write count", wr_cnt - wr0, exp_wr);
        for (int i = 0; i < l; i++) begin
            b = a + i;
            check(bmem[b >> 2][8 * (b % 4) +: 8] == pat(i, tag), "R3 stored byte",
                  int'(bmem[b >> 2][8 * (b % 4) +: 8]), int'(pat(i, tag)));
        end
        check(crc_out == c, poke ? "R7 R8 crc under mid-transfer requests" :
              (load ? "R6 crc" : "R7 crc continues"), int'(crc_out), int'(c));
        crc_model = c;
    endtask

    task automatic bad_cfg(input int a, input int l, input string req);
        int wr0;
        @(negedge clk);
        cfg_start_addr = AW'(a); cfg_len = LW'(l); start = 1'b1;
        wr0 = wr_cnt;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(cfg_err == 1'b1, req, int'(cfg_err), 1);
        check(busy == 1'b0, req, int'(busy), 0);
        repeat (3) @(negedge clk);
        #1;
        check(wr_cnt == wr0 && !busy, req, wr_cnt - wr0, 0);
    endtask

    int tag = 0;
    initial begin
        for (int i = 0; i < WORDS; i++) bmem[i] = 32'hA5A5A5A5;
        repeat (4) @(negedge clk);
        #1;
        check(!busy && !done && !mem_we && !cfg_err, "reset outputs idle", int'(busy), 0);
        check(crc_out == 8'hFF, "R7 reset crc", int'(crc_out), 255);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R6: sweep address phase against length, varied skip and seed.
        for (int a = 0; a < 8; a++) begin
            for (int l = 1; l <= 9; l++) begin
                tag++;
                run_xfer(a + 8 * (tag % 6), l, (a + l) % 4, 8'(tag * 29 + 1), 1'b1, 0, 1'b0, tag);
            end
        end
        // R6: skip at and above the length leaves the seed.
        tag++; run_xfer(3, 4, 4, 8'h5C, 1'b1, 0, 1'b0, tag);
        tag++; run_xfer(9, 2, 7, 8'hFF, 1'b1, 0, 1'b0, tag);
        // R10: gaps between bytes.
        tag++; run_xfer(5, 7, 1, 8'hFF, 1'b1, 2, 1'b0, tag);
        tag++; run_xfer(2, 6, 0, 8'h13, 1'b1, 1, 1'b0, tag);
        // R7: no reload continues the previous CRC.
        tag++; run_xfer(17, 5, 2, 8'h00, 1'b0, 0, 1'b0, tag);
        // R7 R8: start and seed load during a transfer are ignored.
        tag++; run_xfer(21, 8, 1, 8'hFF, 1'b1, 0, 1'b1, tag);
        // R2: buffer ending exactly at the top of RAM is accepted.
        tag++; run_xfer(60, 4, 0, 8'hFF, 1'b1, 0, 1'b0, tag);
        tag++; run_xfer(57, 7, 3, 8'hFF, 1'b1, 1, 1'b0, tag);

        // R1: zero length refused.
        bad_cfg(4, 0, "R1 zero length");
        // R2: one byte past the top refused.
        bad_cfg(60, 5, "R2 overflow");
        bad_cfg(63, 2, "R2 overflow");

        // R9: bytes while idle are ignored.
        begin
            int wr0;
            logic [7:0] c0;
            @(negedge clk);
            wr0 = wr_cnt; c0 = crc_out;
            for (int i = 0; i < 5; i++) begin
                in_valid = 1'b1; in_data = 8'(i * 3 + 1);
                @(negedge clk);
            end
            in_valid = 1'b0;
            repeat (2) @(negedge clk);
            #1;
            check(wr_cnt == wr0, "R9 idle writes", wr_cnt - wr0, 0);
            check(crc_out == c0, "R9 idle crc", int'(crc_out), int'(c0));
            check(!busy, "R9 idle busy", int'(busy), 0);
        end
        finish_sim();
    end
endmodule